// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a 12-bit successive-approximation converter that has a four-way input multiplexer. A start request latches the channel number and runs a sequence of fixed length. The selected input is first held in the sampling phase for five clocks. Then twelve clocks each decide one bit, working from the most significant bit down. The analog capacitor array receives the trial code from this block, and an external comparator answers each trial through a single input pin.

An active-low busy flag is low for the whole sequence. A completed result goes into an output register in a single step, and the register shows that result as a low byte and a high nibble. A conversion can be started in two ways. One is the rising edge of an active-low write strobe while the chip select is low. The other is the rising edge of a second trigger pin, when an enable input allows it. A synchronous abort input comes from a calibration controller. It takes priority over everything else.

Top module: `sar_seq`

## Requirements
- R1: A rising edge of `wr_n` sampled while `cs_n` is low starts a conversion when the block is idle. `busy_n` is low in the first cycle after the clock edge that sees the edge.
- R2: A rising edge of `wr_n` while `cs_n` is high is ignored, and `busy_n` stays high.
- R3: `addr` is captured into `ch_sel` when a conversion starts from `wr_n`. Changes to `addr` during the conversion do not change `ch_sel`.
- R4: `sample` is high during conversion cycles 1 to 5 and low at every other time.
- R5: `busy_n` is low for exactly 17 cycles (cycles 1 to 17). It is high from cycle 18 onward, and the result is valid at that point.
- R6: Cycles 6 to 17 decide bits 11 down to 0. The decision for bit 11 is made in cycle 6, with a `trial` value of 12'h800. A high `cmp_in` at the end of a decision cycle keeps the trial bit, and a low `cmp_in` clears it. With a comparator that is high when the input is at or above `trial`, the result equals the input value.
- R7: `data_lo` is result bits 7:0 and `data_hi` is result bits 11:8.
- R8: The result register changes only at the end of cycle 17. Until then it holds the previous result.
- R9: A start request on either pin during a conversion is ignored and is not held for later. The running conversion completes with its own channel and result.
- R10: When `trig_en` is high, a rising edge on `trig` starts a conversion one cycle later. That conversion keeps the channel already in `ch_sel`.
- R11: When `trig_en` is low, edges on `trig` have no effect.
- R12: When `abort` is high, the sequence stops at once. In that state `busy_n` is low, start requests are ignored and the result is left as it was. `busy_n` returns high in the cycle `abort` falls. Abort wins over a final decision in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Write strobe, active low; start on its rising edge |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 2 | Channel number captured at a write start |
| trig | input | 1 | Alternate start pin, rising edge |
| trig_en | input | 1 | Enables starts from `trig` |
| cmp_in | input | 1 | Comparator result, high keeps the trial bit |
| abort | input | 1 | Synchronous stop from calibration control |
| ch_sel | output | 2 | Latched multiplexer channel |
| sample | output | 1 | High while the input is being sampled |
| trial | output | 12 | Trial code toward the capacitor array |
| busy_n | output | 1 | Low while converting or aborted |
| data_lo | output | 8 | Result bits 7:0 |
| data_hi | output | 4 | Result bits 11:8 |

## Verification
The collision of most interest is abort against the final bit decision. Both act on the same clock edge at the end of cycle 17. The bench raises `abort` in cycle 17 with the comparator set to keep the last bit. The expected outcome is that the result register keeps its previous value and `busy_n` stays low while `abort` is held. The bench also sends a write strobe while abort is high and again in the middle of a conversion. In both cases `busy_n` and the final result must show that nothing started or was queued.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS = 12,
  parameter int NSAMP = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             cs_n,
  input  logic [1:0]       addr,
  input  logic             trig,
  input  logic             trig_en,
  input  logic             cmp_in,
  input  logic             abort,
  output logic [1:0]       ch_sel,
  output logic             sample,
  output logic [NBITS-1:0] trial,
  output logic             busy_n,
  output logic [7:0]       data_lo,
  output logic [NBITS-9:0] data_hi
);
  localparam int LAST = NSAMP + NBITS;
  localparam int CW   = $clog2(LAST + 1);

  logic [CW-1:0]    cnt;
  logic [NBITS-1:0] code, res;
  logic             wr_q, trig_q;

  wire              wr_go   = wr_n & ~wr_q & ~cs_n;
  wire              trig_go = trig_en & trig & ~trig_q;
  wire              idle    = (cnt == '0);
  wire              decide  = (cnt > CW'(NSAMP));
  wire [CW-1:0]     idx     = CW'(LAST) - cnt;
  wire [NBITS-1:0]  mask    = decide ? (NBITS'(1) << idx) : '0;

  assign sample  = ~idle & ~decide;
  assign trial   = code | mask;
  assign busy_n  = idle & ~abort;
  assign data_lo = res[7:0];
  assign data_hi = res[NBITS-1:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      code   <= '0;
      res    <= '0;
      ch_sel <= '0;
      wr_q   <= 1'b1;
      trig_q <= 1'b1;
    end else begin
      wr_q   <= wr_n;
      trig_q <= trig;
      if (abort) begin
        cnt <= '0;
      end else if (idle) begin
        if (wr_go || trig_go) begin
          cnt  <= CW'(1);
          code <= '0;
        end
        if (wr_go) ch_sel <= addr;
      end else begin
        if (decide && cmp_in) code <= code | mask;
        if (cnt == CW'(LAST)) begin
          cnt <= '0;
          res <= cmp_in ? (code | mask) : code;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  p_sample_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> !busy_n);

  p_ch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && !$past(busy_n)) |-> $stable(ch_sel));

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res) |-> ($past(cnt) == CW'(LAST) && !$past(abort)));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> ($past(cnt) == CW'(LAST) || $past(abort)));

  p_first_trial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(NSAMP + 1)) |-> (trial == {1'b1, {(NBITS-1){1'b0}}}));
endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1, cs_n = 1'b1, trig = 1'b0, trig_en = 1'b0, abort = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [11:0] vin = 12'd0;
  logic        cmp_in;
  logic [1:0]  ch_sel;
  logic        sample, busy_n;
  logic [11:0] trial;
  logic [7:0]  data_lo;
  logic [3:0]  data_hi;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;
  assign cmp_in = (vin >= trial);

  sar_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs_n(cs_n), .addr(addr),
    .trig(trig), .trig_en(trig_en), .cmp_in(cmp_in), .abort(abort),
    .ch_sel(ch_sel), .sample(sample), .trial(trial), .busy_n(busy_n),
    .data_lo(data_lo), .data_hi(data_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rd();
    return {data_hi, data_lo};
  endfunction

  task automatic strobe(input logic [1:0] ch);
    @(negedge clk); wr_n = 1'b0; cs_n = 1'b0; addr = ch;
    @(negedge clk); wr_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R5 reset busy_n", busy_n, 1);
    chk("R4 reset sample", sample, 0);
    chk("R7 reset data", rd(), 0);
  endtask

  task automatic run_conv(input logic [11:0] v, input logic [1:0] ch);
    int prev;
    prev = rd();
    vin = v;
    strobe(ch);
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      if (k == 1) begin
        cs_n = 1'b1;
        chk("R1 busy low after start", busy_n, 0);
      end
      if (k == 2) addr = ~ch;
      if (k <= 17) chk("R5 busy low", busy_n, 0);
      chk("R4 sample window", sample, (k <= 5) ? 1 : 0);
      if (k == 6) chk("R6 first trial", trial, 12'h800);
      if (k == 17) chk("R8 previous result held", rd(), prev);
      chk("R3 channel latched", ch_sel, ch);
    end
    chk("R5 busy released", busy_n, 1);
    chk("R6 result", rd(), v);
    chk("R7 low byte", data_lo, v[7:0]);
    chk("R7 high nibble", data_hi, v[11:8]);
  endtask

  task automatic t_cs_ignored();
    int prev;
    prev = rd();
    @(negedge clk); wr_n = 1'b0; cs_n = 1'b1;
    @(negedge clk); wr_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R2 cs high ignored", busy_n, 1);
    end
    chk("R2 data unchanged", rd(), prev);
  endtask

  task automatic t_busy_start();
    vin = 12'h123;
    strobe(2'd2);
    for (int k = 1; k <= 21; k++) begin
      @(negedge clk);
      if (k == 1) cs_n = 1'b1;
      if (k == 8) begin wr_n = 1'b0; cs_n = 1'b0; addr = 2'd0; end
      if (k == 9) begin wr_n = 1'b1; end
      if (k == 10) cs_n = 1'b1;
      if (k == 17) chk("R9 still busy", busy_n, 0);
      if (k >= 18) chk("R9 no queued start", busy_n, 1);
    end
    chk("R9 result", rd(), 12'h123);
    chk("R9 channel", ch_sel, 2);
  endtask

  task automatic t_trig();
    logic [1:0] ch0;
    ch0 = ch_sel;
    trig_en = 1'b1;
    vin = 12'h3C4;
    addr = ch0 + 2'd1;
    @(negedge clk); trig = 1'b1;
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      if (k == 1) trig = 1'b0;
      if (k == 1) chk("R10 trig start", busy_n, 0);
      if (k == 17) chk("R10 busy", busy_n, 0);
    end
    chk("R10 done", busy_n, 1);
    chk("R10 result", rd(), 12'h3C4);
    chk("R10 channel kept", ch_sel, ch0);
  endtask

  task automatic t_trig_off();
    trig_en = 1'b0;
    @(negedge clk); trig = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R11 trig disabled", busy_n, 1);
    end
    trig = 1'b0;
    @(negedge clk);
    chk("R11 data unchanged", rd(), 12'h3C4);
  endtask

  task automatic t_abort();
    int prev;
    prev = rd();
    vin = 12'h456;
    strobe(2'd1);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k == 1) cs_n = 1'b1;
    end
    abort = 1'b1;
    #1 chk("R12 busy low at abort", busy_n, 0);
    @(negedge clk); wr_n = 1'b0; cs_n = 1'b0; addr = 2'd3;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    chk("R12 busy held low", busy_n, 0);
    abort = 1'b0;
    #1 chk("R12 busy high after abort", busy_n, 1);
    repeat (3) begin
      @(negedge clk);
      chk("R12 no restart", busy_n, 1);
    end
    chk("R12 result untouched", rd(), prev);
    chk("R12 channel untouched", ch_sel, 1);
  endtask

  task automatic t_abort_last();
    int prev;
    prev = rd();
    vin = 12'hFFF;
    strobe(2'd3);
    for (int k = 1; k <= 17; k++) begin
      @(negedge clk);
      if (k == 1) cs_n = 1'b1;
    end
    abort = 1'b1;
    @(negedge clk);
    chk("R12 abort beats last decision busy", busy_n, 0);
    chk("R12 abort beats last decision data", rd(), prev);
    abort = 1'b0;
    @(negedge clk);
    chk("R12 released", busy_n, 1);
    chk("R12 data after release", rd(), prev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_conv(12'hA5C, 2'd1);
    run_conv(12'h000, 2'd2);
    run_conv(12'hFFF, 2'd3);
    run_conv(12'h7FF, 2'd0);
    run_conv(12'h800, 2'd2);
    t_cs_ignored();
    t_busy_start();
    t_trig();
    t_trig_off();
    t_abort();
    t_abort_last();
    run_conv(12'h001, 2'd0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule